// File: doc/BRIEF.md
# Single-Step Trap Interrupt Generator

This block lets a debug monitor run exactly a fixed number of user instructions and then regain control. The CPU writes a control bit on one of its output ports. While that bit is 1 the trap is disarmed: an internal fetch counter is held at zero and the active-low non-maskable interrupt request stays high. When the monitor writes 0 to the bit, just before it jumps into user code, the counter starts counting opcode-fetch cycles. It counts only clean falling edges of the active-low M1 strobe. After the fifth counted fetch it pulls the interrupt request low. The CPU then enters its non-maskable handler at address 0x0066, and that handler writes 1 back to the control bit, which releases the request.

M1 and the interrupt-acknowledge indication are asynchronous to the block clock. Both pass through two-flop synchronisers. The synchronised M1 level then goes through a filter that ignores any excursion shorter than two clock cycles, so a strobe that toggles briefly (for example while the CPU is stalled mid-fetch) cannot bring the trap forward. An M1 cycle marked as an interrupt acknowledge is not an opcode fetch and is not counted. The count saturates at its terminal value, so a trap that stays armed raises only one request. The block has no stream interface: every pin is a plain level or strobe, and there is no back-pressure.

Top module: `step_trap_nmi`

## Requirements
- R1: A synchronous reset makes `nmi_n_o` read 1 after the clock edge that samples `rst`, and it clears the fetch count. During that edge the control bit is treated as 1, whatever `trap_hold_i` is.
- R2: While `trap_hold_i` is 1, `nmi_n_o` stays 1 whatever M1 activity occurs.
- R3: With `trap_hold_i` at 0, `nmi_n_o` goes to 0 after the fifth counted falling edge of `m1_n_i`, and not before. If `m1_n_i` falls between clock edges, `nmi_n_o` is 0 after the fifth rising clock edge that follows and still 1 after the fourth.
- R4: Once `nmi_n_o` is 0 with the trap armed, it stays 0 through any further M1 activity. The count never exceeds five, so no second request is produced.
- R5: Changing `trap_hold_i` to 1 returns `nmi_n_o` to 1 after the next rising clock edge. When the trap is armed again, five new fetches are needed.
- R6: A low level on `m1_n_i` lasting fewer than two clock cycles is not counted. A high gap of fewer than two cycles inside a low phase does not split it into two fetches. Low and high phases of two cycles or more are counted normally.
- R7: A falling edge of `m1_n_i` is not counted while `iack_i` is 1 (interrupt acknowledge, held for the whole low phase).
- R8: M1 edges that occur while the trap is disarmed are not remembered. Counting after release starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_hold_i | input | 1 | Port control bit: 1 holds the counter cleared, 0 arms the trap |
| m1_n_i | input | 1 | Active-low opcode-fetch strobe from the CPU, asynchronous |
| iack_i | input | 1 | High while the current M1 cycle is an interrupt acknowledge, asynchronous |
| nmi_n_o | output | 1 | Active-low non-maskable interrupt request |

## Verification
A fetch counter that is off by one, fails to saturate or misses a clear moves the falling edge of `nmi_n_o` by a whole M1 period. It can also produce a second low phase or a request under hold. This shows at the port within one fetch of the fault. A fault in the synchroniser or the filter changes which pulse is counted and when. That appears as a latency error of one or more clock cycles on the fifth fetch, or as a glitch or an acknowledge cycle being counted. The bench sweeps every acknowledge pattern over eight fetches and every short pulse and gap width up to the filter bound, and compares each result with an arithmetic count.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned DEF_TRAP_COUNT  = 5;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_GLITCH_CYC  = 2;

  // bits needed to hold the values 0..n
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/trap_sync.sv
module trap_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/trap_deglitch.sv
module trap_deglitch
  import trap_pkg::*;
#(
  parameter int unsigned GLITCH_CYC = DEF_GLITCH_CYC
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,    // synchronised strobe level
  input  logic block_i,  // suppress counting of this falling edge
  output logic fall_o    // one-cycle strobe per accepted falling edge
);
  localparam int unsigned SW = width_for(GLITCH_CYC);

  logic          filt_q;
  logic [SW-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b1;
      stab_q <= '0;
      fall_o <= 1'b0;
    end else begin
      fall_o <= 1'b0;
      if (lvl_i != filt_q) begin
        if (stab_q == SW'(GLITCH_CYC - 1)) begin
          filt_q <= lvl_i;
          stab_q <= '0;
          fall_o <= filt_q & ~block_i;
        end else begin
          stab_q <= stab_q + 1'b1;
        end
      end else begin
        stab_q <= '0;
      end
    end
  end
endmodule

// File: rtl/trap_counter.sv
module trap_counter #(
  parameter int unsigned LIMIT = 5,
  parameter int unsigned CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i)                         cnt_o <= '0;
    else if (step_i && (cnt_o != CW'(LIMIT)))   cnt_o <= cnt_o + 1'b1;
  end

  assign hit_o = (cnt_o == CW'(LIMIT));
endmodule

// File: rtl/step_trap_nmi.sv
module step_trap_nmi
  import trap_pkg::*;
#(
  parameter int unsigned TRAP_COUNT  = DEF_TRAP_COUNT,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned GLITCH_CYC  = DEF_GLITCH_CYC
) (
  input  logic clk,
  input  logic rst,
  input  logic trap_hold_i,
  input  logic m1_n_i,
  input  logic iack_i,
  output logic nmi_n_o
);
  localparam int unsigned CW = width_for(TRAP_COUNT);

  logic          hold_q;
  logic          m1_s, iack_s;
  logic          fall_q;
  logic [CW-1:0] cnt_q;
  logic          hit;

  // control bit register; reads as "hold" out of reset
  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b1;
    else     hold_q <= trap_hold_i;
  end

  trap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_m1_sync (
    .clk(clk), .rst(rst), .d(m1_n_i), .q(m1_s)
  );

  trap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_iack_sync (
    .clk(clk), .rst(rst), .d(iack_i), .q(iack_s)
  );

  trap_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst(rst), .lvl_i(m1_s), .block_i(iack_s), .fall_o(fall_q)
  );

  trap_counter #(.LIMIT(TRAP_COUNT), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(hold_q), .step_i(fall_q),
    .cnt_o(cnt_q), .hit_o(hit)
  );

  assign nmi_n_o = ~(hit & ~hold_q);
endmodule

// File: rtl/trap_nmi_checker.sv
module trap_nmi_checker #(
  parameter int unsigned TRAP_COUNT = 5,
  parameter int unsigned CW         = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          hold_q,
  input logic [CW-1:0] cnt_q,
  input logic          fall_q,
  input logic          nmi_n_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> nmi_n_o); // R1
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst) hold_q |-> nmi_n_o); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(TRAP_COUNT)); // R4
  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (rst) !nmi_n_o |=> (!nmi_n_o || hold_q)); // R4
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst) !hold_q |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0)); // R3
  AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (rst) hold_q |=> (cnt_q == '0)); // R8
  AST_FALL_PULSE: assert property (@(posedge clk) disable iff (rst) fall_q |=> !fall_q); // R6
endmodule

bind step_trap_nmi trap_nmi_checker #(.TRAP_COUNT(TRAP_COUNT), .CW(CW)) u_trap_chk (
  .clk(clk), .rst(rst), .hold_q(hold_q), .cnt_q(cnt_q),
  .fall_q(fall_q), .nmi_n_o(nmi_n_o)
);

// File: tb/test_step_trap_nmi.sv
module test_step_trap_nmi;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_hold_i = 1'b1;
  logic m1_n_i = 1'b1;
  logic iack_i = 1'b0;
  logic nmi_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam int TRAPN = 5;

  always #2.5 clk = ~clk;

  step_trap_nmi i_step_trap_nmi (
    .clk(clk), .rst(rst), .trap_hold_i(trap_hold_i),
    .m1_n_i(m1_n_i), .iack_i(iack_i), .nmi_n_o(nmi_n_o)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (nmi_n_o !== exp) begin
      fails++;
      $display("FAIL %s: nmi_n_o=%b expected %b", req, nmi_n_o, exp);
    end
  endtask

  task automatic pulse(input logic ia, input int lo, input int hi);
    @(negedge clk); m1_n_i = 1'b0; iack_i = ia;
    repeat (lo) @(negedge clk);
    m1_n_i = 1'b1; iack_i = 1'b0;
    repeat (hi) @(negedge clk);
  endtask

  task automatic arm();
    @(negedge clk); trap_hold_i = 1'b1;
    repeat (2) @(negedge clk);
    trap_hold_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: nmi_n_o=%b expected run to end", nmi_n_o);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(1'b1, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(1'b1, "R1 after reset");

    // R2 / R8: fetches while held change nothing, and are forgotten
    for (int i = 0; i < 8; i++) begin
      pulse(1'b0, 4, 4);
      chk(1'b1, "R2 held");
    end
    @(negedge clk); trap_hold_i = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 1; i <= 4; i++) begin
      pulse(1'b0, 4, 4);
      chk(1'b1, "R8 fresh count");
    end
    pulse(1'b0, 4, 4);
    chk(1'b0, "R8 fifth after release");

    // R3 count and exact latency of the fifth fetch
    arm();
    for (int i = 1; i <= 4; i++) begin
      pulse(1'b0, 3, 3);
      chk(1'b1, "R3 before fifth");
    end
    @(negedge clk); m1_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(1'b1, "R3 four edges after fifth fall");
    @(negedge clk);
    chk(1'b0, "R3 five edges after fifth fall");
    m1_n_i = 1'b1;
    repeat (3) @(negedge clk);

    // R4 saturation, R5 release and re-arm
    for (int i = 0; i < 10; i++) begin
      pulse(1'b0, 4, 4);
      chk(1'b0, "R4 stays asserted");
    end
    @(negedge clk); trap_hold_i = 1'b1;
    @(negedge clk);
    chk(1'b1, "R5 release next edge");
    repeat (2) @(negedge clk);
    trap_hold_i = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 1; i <= 5; i++) begin
      pulse(1'b0, 4, 4);
      chk((i >= TRAPN) ? 1'b0 : 1'b1, "R5 re-arm count");
    end

    // R1 reset while asserted and armed input
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(1'b1, "R1 reset clears request");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 1; i <= 5; i++) begin
      pulse(1'b0, 4, 4);
      chk((i >= TRAPN) ? 1'b0 : 1'b1, "R1 count restarts");
    end

    // R6 short low pulses
    for (int w = 1; w <= 3; w++) begin
      arm();
      for (int i = 0; i < 4; i++) pulse(1'b0, 4, 4);
      pulse(1'b0, w, 4);
      chk((w >= 2) ? 1'b0 : 1'b1, "R6 low width");
    end
    // R6 short high gaps inside a low phase
    for (int g = 1; g <= 3; g++) begin
      arm();
      for (int i = 0; i < 3; i++) pulse(1'b0, 4, 4);
      @(negedge clk); m1_n_i = 1'b0;
      repeat (3) @(negedge clk);
      m1_n_i = 1'b1;
      repeat (g) @(negedge clk);
      m1_n_i = 1'b0;
      repeat (3) @(negedge clk);
      m1_n_i = 1'b1;
      repeat (4) @(negedge clk);
      chk((g >= 2) ? 1'b0 : 1'b1, "R6 high gap");
    end

    // R7 exhaustive acknowledge patterns over eight fetches
    for (int mask = 0; mask < 256; mask++) begin
      int counted;
      arm();
      counted = 0;
      for (int i = 0; i < 8; i++) begin
        pulse(mask[i], 4, 4);
        if (!mask[i]) counted++;
        chk((counted >= TRAPN) ? 1'b0 : 1'b1, "R7 acknowledge sweep");
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule